// File: doc/BRIEF.md
# Programmable TDM Input Frame Aligner

This block takes one serial time-division-multiplexed input stream and moves its frame boundary to a programmable position relative to a master frame pulse. Three settings place the stream's channel zero. The first is a delay counted in whole channels. The second is a delay of zero to seven bits. The third is a sampling phase that picks which quarter of each bit cell is captured. Each stream of a larger device gets its own copy of the block, so every stream can have its own boundary.

The block runs on a sampling clock that is four times the fastest bit rate. The stream rate is chosen among a set of binary steps, from the base rate up to 2^(RATES-1) times the base rate. A master frame lasts a fixed number of sampling clocks at every rate, so a faster stream carries proportionally more channels. The block outputs each recovered byte with its realigned channel number, plus a start-of-frame strobe in the stream's own frame timing. Offset settings take effect only at a master frame pulse, so no frame is ever aligned partly by old settings and partly by new ones.

Top module: `tdm_align`

## Requirements
- R1: While reset is high, all outputs are 0. After reset the active settings are rate code 0, channel delay 0, bit delay 0 and phase code 2 (the 3/4 position). The master tick count starts at 0 in the first clock after reset and wraps every FRAME = BASE_CH*32*2^(RATES-1) clocks.
- R2: The configuration inputs are copied into the active settings only at a clock edge where `fp_i` is high, and that edge also restarts the master tick count at 0. Input changes at any other time have no effect on the outputs.
- R3: For rate code r (codes at or above RATES act as RATES-1), a quarter bit lasts Q = 2^(RATES-1-r) clocks and a bit lasts 4Q clocks. A frame then holds BASE_CH*2^r channels of 8 bits.
- R4: The offset in bits is (8*channel delay + bit delay) modulo the bit count of the frame. Bit 7 of local channel 0 starts at master tick offset*4Q, and local channel c follows it after 8c bits.
- R5: Phase code p (0 = 1/4, 1 = 1/2, 2 = 3/4, 3 = 4/4) samples each bit at the clock edge that ends master tick (bit start + (p+1)*Q - 1).
- R6: Bits are assembled most significant first. One clock after the edge that samples a channel's last bit, `valid_o` is high for exactly one clock, with that byte on `byte_o` and the local channel index on `ch_o`. This happens once per channel per frame, in rising channel order.
- R7: `sof_o` is high for exactly one clock, one clock after the edge that ends the master tick where the local frame position is 0. The next byte after it belongs to channel 0.
- R8: Data that arrives up to half a bit late relative to the local cell is still recovered exactly when phase code 2 or 3 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, four times the fastest bit rate |
| rst_i | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Master frame pulse, one clock wide; restarts the frame and loads settings |
| din_i | input | 1 | Serial data line of the stream |
| rate_i | input | clog2(RATES) | Rate code r, stream rate = base rate * 2^r |
| ch_dly_i | input | clog2(BASE_CH*2^(RATES-1)) | Channel-granularity delay |
| bit_dly_i | input | 3 | Whole-bit delay, 0 to 7 |
| phase_i | input | 2 | Quarter-bit sampling phase code |
| byte_o | output | 8 | Recovered byte, first received bit in bit 7 |
| ch_o | output | clog2(BASE_CH*2^(RATES-1)) | Local channel index of `byte_o` |
| valid_o | output | 1 | One-clock strobe marking a recovered byte |
| sof_o | output | 1 | One-clock strobe at local frame position 0 |

## Verification
The hardest case to reach from the ports is the frame in which the alignment changes. In that frame, bytes whose bits were sampled across the master pulse mix two alignments. Then comes the following frame, where settings driven in the middle of the frame must be ignored. The stimulus sets a new configuration, pulses the master frame, and keeps the same inputs for one more pulse. It then checks a whole frame against an arithmetic model of the stream and scrambles every configuration input halfway through that checked frame. The sweep covers every rate, every phase and offsets that wrap past the frame end. A late-data pass shifts the driven stream by two quarter bits, so that the 1/4 and 1/2 phases capture the wrong bits while 3/4 and 4/4 recover the bytes.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;

    localparam int unsigned BITS_PER_CH  = 8;
    localparam int unsigned QTRS_PER_BIT = 4;

    // Quarter-bit instant at which a bit cell is captured.
    typedef enum logic [1:0] {
        SAMP_QTR  = 2'd0,
        SAMP_HALF = 2'd1,
        SAMP_3QTR = 2'd2,
        SAMP_END  = 2'd3
    } samp_pt_e;

    // Per-clock events decoded from the local frame position.
    typedef struct packed {
        logic samp;   // this clock edge captures a bit
        logic last;   // the captured bit is the final bit of its channel
        logic zero;   // local frame position is zero
    } slot_evt_t;

    function automatic int unsigned frame_ticks(int unsigned base_ch, int unsigned rates);
        return base_ch * BITS_PER_CH * QTRS_PER_BIT * (1 << (rates - 1));
    endfunction

    function automatic int unsigned max_chans(int unsigned base_ch, int unsigned rates);
        return base_ch << (rates - 1);
    endfunction

    // log2 of the quarter-bit length in clocks for a given rate code.
    function automatic int unsigned quarter_shift(int unsigned rate, int unsigned rates);
        return rates - 1 - rate;
    endfunction

endpackage

// File: rtl/tdm_align_cfg.sv
module tdm_align_cfg
    import tdm_align_pkg::*;
#(
    parameter int unsigned BASE_CH = 32,
    parameter int unsigned RATES   = 5,
    localparam int unsigned MAX_CH = max_chans(BASE_CH, RATES),
    localparam int unsigned CHW    = $clog2(MAX_CH),
    localparam int unsigned RW     = (RATES > 1) ? $clog2(RATES) : 1,
    localparam int unsigned OBW    = CHW + 3,
    localparam int unsigned FW     = OBW + 2
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           fp_i,
    input  logic [RW-1:0]  rate_i,
    input  logic [CHW-1:0] ch_dly_i,
    input  logic [2:0]     bit_dly_i,
    input  logic [1:0]     phase_i,
    output logic [RW-1:0]  rate_o,
    output samp_pt_e       phase_o,
    output logic [FW-1:0]  off_o
);

    logic [RW-1:0]  rate_c;
    logic [OBW-1:0] bits_mask;
    logic [OBW-1:0] off_bits;
    logic [FW-1:0]  off_ticks;

    // Offset computed from the raw inputs; loaded only at the frame pulse.
    always_comb begin
        rate_c    = (int'(rate_i) >= int'(RATES)) ? RW'(RATES - 1) : rate_i;
        bits_mask = OBW'(((BASE_CH * BITS_PER_CH) << rate_c) - 1);
        off_bits  = ({ch_dly_i, 3'b000} + OBW'(bit_dly_i)) & bits_mask;
        off_ticks = FW'({off_bits, 2'b00}) << quarter_shift(int'(rate_c), RATES);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rate_o  <= '0;
            phase_o <= SAMP_3QTR;
            off_o   <= '0;
        end else if (fp_i) begin
            rate_o  <= rate_c;
            phase_o <= samp_pt_e'(phase_i);
            off_o   <= off_ticks;
        end
    end

endmodule

// File: rtl/tdm_align_timer.sv
module tdm_align_timer
    import tdm_align_pkg::*;
#(
    parameter int unsigned BASE_CH = 32,
    parameter int unsigned RATES   = 5,
    localparam int unsigned MAX_CH = max_chans(BASE_CH, RATES),
    localparam int unsigned CHW    = $clog2(MAX_CH),
    localparam int unsigned RW     = (RATES > 1) ? $clog2(RATES) : 1,
    localparam int unsigned FW     = CHW + 5
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           fp_i,
    input  logic [RW-1:0]  rate_i,
    input  samp_pt_e       phase_i,
    input  logic [FW-1:0]  off_i,
    output slot_evt_t      evt_o,
    output logic [CHW-1:0] chan_o
);

    logic [FW-1:0] mtick_q;
    logic [FW-1:0] loc;
    logic [FW-1:0] sub_mask;
    logic [FW-1:0] qidx;
    logic [FW-1:0] bidx;
    int unsigned   qsh;

    // Master tick: the frame length is a power of two, so wrap is free.
    always_ff @(posedge clk_i) begin
        if (rst_i || fp_i) begin
            mtick_q <= '0;
        end else begin
            mtick_q <= mtick_q + 1'b1;
        end
    end

    always_comb begin
        qsh        = quarter_shift(int'(rate_i), RATES);
        loc        = mtick_q - off_i;
        sub_mask   = FW'((1 << qsh) - 1);
        qidx       = loc >> qsh;
        bidx       = loc >> (qsh + 2);
        evt_o.samp = ((loc & sub_mask) == sub_mask) && (qidx[1:0] == phase_i);
        evt_o.last = (bidx[2:0] == 3'd7);
        evt_o.zero = (loc == '0);
        chan_o     = CHW'(bidx >> 3);
    end

endmodule

// File: rtl/tdm_align_deser.sv
module tdm_align_deser
    import tdm_align_pkg::*;
#(
    parameter int unsigned CHW = 9
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           din_i,
    input  slot_evt_t      evt_i,
    input  logic [CHW-1:0] chan_i,
    output logic [7:0]     byte_o,
    output logic [CHW-1:0] ch_o,
    output logic           valid_o,
    output logic           sof_o
);

    logic [BITS_PER_CH-2:0] shift_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shift_q <= '0;
            byte_o  <= '0;
            ch_o    <= '0;
            valid_o <= 1'b0;
            sof_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            sof_o   <= evt_i.zero;
            if (evt_i.samp) begin
                if (evt_i.last) begin
                    byte_o  <= {shift_q, din_i};
                    ch_o    <= chan_i;
                    valid_o <= 1'b1;
                end else begin
                    shift_q <= {shift_q[BITS_PER_CH-3:0], din_i};
                end
            end
        end
    end

endmodule

// File: rtl/tdm_align.sv
module tdm_align
    import tdm_align_pkg::*;
#(
    parameter int unsigned BASE_CH = 32,
    parameter int unsigned RATES   = 5,
    localparam int unsigned MAX_CH = max_chans(BASE_CH, RATES),
    localparam int unsigned CHW    = $clog2(MAX_CH),
    localparam int unsigned RW     = (RATES > 1) ? $clog2(RATES) : 1,
    localparam int unsigned FW     = CHW + 5
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           fp_i,
    input  logic           din_i,
    input  logic [RW-1:0]  rate_i,
    input  logic [CHW-1:0] ch_dly_i,
    input  logic [2:0]     bit_dly_i,
    input  logic [1:0]     phase_i,
    output logic [7:0]     byte_o,
    output logic [CHW-1:0] ch_o,
    output logic           valid_o,
    output logic           sof_o
);

    logic [RW-1:0]  act_rate;
    samp_pt_e       act_phase;
    logic [FW-1:0]  act_off;
    slot_evt_t      evt;
    logic [CHW-1:0] loc_chan;

    tdm_align_cfg #(
        .BASE_CH (BASE_CH),
        .RATES   (RATES)
    ) u_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .fp_i      (fp_i),
        .rate_i    (rate_i),
        .ch_dly_i  (ch_dly_i),
        .bit_dly_i (bit_dly_i),
        .phase_i   (phase_i),
        .rate_o    (act_rate),
        .phase_o   (act_phase),
        .off_o     (act_off)
    );

    tdm_align_timer #(
        .BASE_CH (BASE_CH),
        .RATES   (RATES)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .fp_i    (fp_i),
        .rate_i  (act_rate),
        .phase_i (act_phase),
        .off_i   (act_off),
        .evt_o   (evt),
        .chan_o  (loc_chan)
    );

    tdm_align_deser #(
        .CHW (CHW)
    ) u_deser (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .din_i   (din_i),
        .evt_i   (evt),
        .chan_i  (loc_chan),
        .byte_o  (byte_o),
        .ch_o    (ch_o),
        .valid_o (valid_o),
        .sof_o   (sof_o)
    );

endmodule

// File: rtl/tdm_align_chk.sv
module tdm_align_chk
    import tdm_align_pkg::*;
#(
    parameter int unsigned BASE_CH = 32,
    parameter int unsigned RATES   = 5,
    localparam int unsigned MAX_CH = max_chans(BASE_CH, RATES),
    localparam int unsigned CHW    = $clog2(MAX_CH),
    localparam int unsigned RW     = (RATES > 1) ? $clog2(RATES) : 1,
    localparam int unsigned FW     = CHW + 5
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           fp_i,
    input logic           valid_o,
    input logic           sof_o,
    input logic [CHW-1:0] ch_o,
    input logic [RW-1:0]  act_rate,
    input logic [1:0]     act_phase,
    input logic [FW-1:0]  act_off
);

    logic           rst_q;
    logic           fp_q;
    logic           have_last;
    logic [CHW-1:0] last_ch;
    logic           want_ch0;
    logic [CHW-1:0] ch_mask;

    assign ch_mask = CHW'((BASE_CH << act_rate) - 1);

    p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !fp_i |=> ($stable(act_rate) && $stable(act_phase) && $stable(act_off)));

    p_ch_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (int'(ch_o) < int'(BASE_CH << $past(act_rate))));

    p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    p_sof_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        sof_o |=> !sof_o);

    always_ff @(posedge clk_i) begin
        rst_q <= rst_i;
        fp_q  <= fp_i;
        if (rst_q === 1'b1 && rst_i === 1'b0) begin
            p_reset_defaults_r1: assert (act_rate == '0 && act_phase == SAMP_3QTR && act_off == '0);
        end
        if (!rst_i && valid_o && have_last) begin
            p_ch_order_r6: assert (ch_o == ((last_ch + 1'b1) & ch_mask));
        end
        if (!rst_i && valid_o && want_ch0) begin
            p_sof_then_ch0_r7: assert (ch_o == '0);
        end
        if (rst_i || fp_i || fp_q) begin
            have_last <= 1'b0;
            want_ch0  <= 1'b0;
        end else begin
            if (valid_o) begin
                have_last <= 1'b1;
                last_ch   <= ch_o;
                want_ch0  <= 1'b0;
            end
            if (sof_o) begin
                want_ch0 <= 1'b1;
            end
        end
    end

endmodule

bind tdm_align tdm_align_chk #(
    .BASE_CH (BASE_CH),
    .RATES   (RATES)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .fp_i      (fp_i),
    .valid_o   (valid_o),
    .sof_o     (sof_o),
    .ch_o      (ch_o),
    .act_rate  (act_rate),
    .act_phase (act_phase),
    .act_off   (act_off)
);

// File: tb/test_tdm_align.sv
module test_tdm_align;
    import tdm_align_pkg::*;

    localparam int unsigned BASE_CH = 2;
    localparam int unsigned RATES   = 3;
    localparam int unsigned MAX_CH  = max_chans(BASE_CH, RATES);
    localparam int unsigned CHW     = $clog2(MAX_CH);
    localparam int unsigned RW      = (RATES > 1) ? $clog2(RATES) : 1;
    localparam int          FRAME   = int'(frame_ticks(BASE_CH, RATES));

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           fp = 1'b0;
    logic           din = 1'b0;
    logic [RW-1:0]  rate_in = '0;
    logic [CHW-1:0] chd_in = '0;
    logic [2:0]     bitd_in = '0;
    logic [1:0]     ph_in = 2'd2;
    logic [7:0]     byte_o;
    logic [CHW-1:0] ch_o;
    logic           valid_o;
    logic           sof_o;

    // Bench model of the active settings and the master tick.
    int    m_rate = 0, m_ph = 2, m_off = 0, m_skew = 0, salt = 0;
    int    skew_next = 0, salt_next = 0;
    bit    skip = 1'b0;
    int    bt = 0;
    string ctx = "R1";
    int    checks = 0, fails = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    tdm_align #(
        .BASE_CH (BASE_CH),
        .RATES   (RATES)
    ) i_tdm_align (
        .clk_i     (clk),
        .rst_i     (rst),
        .fp_i      (fp),
        .din_i     (din),
        .rate_i    (rate_in),
        .ch_dly_i  (chd_in),
        .bit_dly_i (bitd_in),
        .phase_i   (ph_in),
        .byte_o    (byte_o),
        .ch_o      (ch_o),
        .valid_o   (valid_o),
        .sof_o     (sof_o)
    );

    function automatic int qlen(int r);
        return 1 << (RATES - 1 - r);
    endfunction

    function automatic int off_ticks(int r, int chd, int bd);
        int nb;
        nb = (BASE_CH * 8) << r;
        return ((chd * 8 + bd) % nb) * 4 * qlen(r);
    endfunction

    function automatic logic [7:0] pat(int ch);
        return 8'((ch * 53 + 58 + salt * 29) & 255);
    endfunction

    // Level driven on the line at master tick t by an ideal stream.
    function automatic logic din_at(int t);
        int bl, rel, k;
        logic [7:0] p;
        bl  = 4 * qlen(m_rate);
        rel = ((t - m_off - m_skew) % FRAME + FRAME) % FRAME;
        k   = rel / bl;
        p   = pat(k / 8);
        return p[7 - (k % 8)];
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, ctx, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int nr, noff;
        if (rst) begin
            bt <= 0; m_rate <= 0; m_ph <= 2; m_off <= 0;
            m_skew <= 0; salt <= 0; skip <= 1'b0;
        end else if (fp) begin
            nr   = (int'(rate_in) >= RATES) ? RATES - 1 : int'(rate_in);
            noff = off_ticks(nr, int'(chd_in), int'(bitd_in));
            skip <= (nr != m_rate) || (int'(ph_in) != m_ph) || (noff != m_off) ||
                    (skew_next != m_skew) || (salt_next != salt);
            m_rate <= nr; m_ph <= int'(ph_in); m_off <= noff;
            m_skew <= skew_next; salt <= salt_next;
            bt <= 0;
        end else begin
            bt <= (bt + 1) % FRAME;
        end
    end

    task automatic check_outputs();
        int q, bl, ts, lt, ech;
        bit ev, es;
        logic [7:0] eb;
        q   = qlen(m_rate);
        bl  = 4 * q;
        ts  = (bt + FRAME - 1) % FRAME;
        lt  = ((ts - m_off) % FRAME + FRAME) % FRAME;
        ev  = ((lt % bl) == (m_ph + 1) * q - 1) && (((lt / bl) % 8) == 7);
        ech = lt / bl / 8;
        if (ev || valid_o) begin
            chk(valid_o == ev, "R6", "valid strobe", int'(valid_o), int'(ev));
            if (ev && valid_o) begin
                eb = '0;
                for (int b = 0; b < 8; b++) begin
                    eb = {eb[6:0], din_at((m_off + (ech * 8 + b) * bl + (m_ph + 1) * q - 1) % FRAME)};
                end
                chk(int'(ch_o) == ech, "R6", "channel index", int'(ch_o), ech);
                chk(byte_o == eb, "R5", "sampled byte", int'(byte_o), int'(eb));
                if (m_skew == 0) begin
                    chk(byte_o == pat(ech), "R4", "aligned byte", int'(byte_o), int'(pat(ech)));
                end else if (m_ph >= 2) begin
                    chk(byte_o == pat(ech), "R8", "late data byte", int'(byte_o), int'(pat(ech)));
                end
            end
        end
        es = (ts == m_off);
        if (es || sof_o) begin
            chk(sof_o == es, "R7", "frame start strobe", int'(sof_o), int'(es));
        end
    endtask

    always @(negedge clk) begin
        din <= din_at(bt);
        if (!rst && !skip && !done) begin
            check_outputs();
        end
    end

    task automatic frame_pulse();
        do @(negedge clk); while (bt != FRAME - 1);
        fp = 1'b1;
        @(negedge clk);
        fp = 1'b0;
    endtask

    task automatic apply(int r, int chd, int bd, int ph, int sk, string c);
        rate_in   = RW'(r);
        chd_in    = CHW'(chd);
        bitd_in   = 3'(bd);
        ph_in     = 2'(ph);
        skew_next = sk * qlen(r);
        salt_next = salt_next + 1;
        frame_pulse();
        ctx = c;
        frame_pulse();
        repeat (FRAME / 2) @(negedge clk);
        // R2: these values must not reach the active settings before the next pulse.
        rate_in = ~rate_in;
        chd_in  = chd_in + 3'd3;
        bitd_in = ~bitd_in;
        ph_in   = ~ph_in;
        ctx     = "R2";
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(valid_o == 1'b0 && sof_o == 1'b0 && byte_o == 8'd0 && ch_o == '0,
            "R1", "outputs during reset", int'({valid_o, sof_o, byte_o}), 0);
        rst = 1'b0;
        ctx = "R1";
        frame_pulse();
        frame_pulse();
        for (int r = 0; r < int'(RATES); r++) begin
            for (int ph = 0; ph < 4; ph++) begin
                for (int o = 0; o < 4; o++) begin
                    int chans;
                    chans = int'(BASE_CH) << r;
                    case (o)
                        0: apply(r, 0, 0, ph, 0, "R3");
                        1: apply(r, 1, 3, ph, 0, "R3");
                        2: apply(r, chans - 1, 7, ph, 0, "R4");
                        default: apply(r, (chans + 1) % int'(MAX_CH), 5, ph, 0, "R4");
                    endcase
                end
            end
            for (int ph = 1; ph < 4; ph++) begin
                apply(r, 1, 2, ph, 2, "R8");
            end
        end
        frame_pulse();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R6 [watchdog] run did not finish: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule